// File: doc/BRIEF.md
# Modem Line Status Register with Change Capture

This block presents the 8-bit modem-line status word of a serial port to the host. Four active-low handshake inputs arrive at the pins: clear-to-send, data-set-ready, ring and carrier-detect. Each passes through a two-flop synchronizer. The block then reports the inverted, active-high level of each one in the upper nibble. The lower nibble holds sticky change flags. Clear-to-send, data-set-ready and carrier-detect flag a change in either direction. Ring flags only the end of a ring pulse. All four flags clear when the host reads the register.

In loopback the upper nibble is taken from four modem-control output bits instead of the pins, and change capture works on that looped level. Toggling a control bit therefore produces the matching change flag, which lets software test the interrupt path without external wiring. An interrupt request is raised while any change flag is set and the modem-status interrupt enable is high.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, with all pins held high (inactive), `status_o` reads 0x00 and `irq_o` is 0.
- R2: Outside loopback, bits 4, 5, 6 and 7 equal the inverse of `modem_n_i[0]` (clear-to-send), `[1]` (data-set-ready), `[2]` (ring) and `[3]` (carrier-detect). A pin change becomes visible after two rising clock edges.
- R3: Bit 0 sets when the reported clear-to-send level changes in either direction. Bit 1 does the same for data-set-ready. Either bit is visible one edge after the level changes.
- R4: Bit 3 sets when the reported carrier-detect level changes in either direction.
- R5: Bit 2 sets only when the ring pin goes from low to high, so that bit 6 falls from 1 to 0. A high-to-low pin transition leaves bit 2 unchanged.
- R6: A cycle with `rd_strobe_i` high clears bits 3:0 at the next edge. A change detected at that same edge stays set.
- R7: `irq_o` is 1 exactly when `msi_en_i` is 1 and at least one of bits 3:0 is 1.
- R8: With `loop_en_i` high, bits 4, 5, 6 and 7 follow `mctl_i[0]` (request-to-send), `[1]` (data-terminal-ready), `[2]` (aux output 1) and `[3]` (aux output 2) in the same cycle. Pin activity then has no effect on them.
- R9: In loopback, change capture uses the looped control bits. Toggling `mctl_i[0]` sets bit 0 at the next edge, and toggling `mctl_i[2]` from 1 to 0 sets bit 2.
- R10: A set change flag holds its value until a read, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_n_i | input | 4 | Active-low pins: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier-detect |
| rd_strobe_i | input | 1 | Host read of the register; clears the change flags |
| loop_en_i | input | 1 | Loopback select |
| mctl_i | input | 4 | Modem-control bits: [0] request-to-send, [1] data-terminal-ready, [2] aux 1, [3] aux 2 |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Register value: [7:4] levels, [3:0] change flags |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A host read and a fresh line change can land on the same clock edge. The read must then clear the old flags without losing the new one. The bench provokes this in loopback by raising `rd_strobe_i` in the same cycle that it toggles a control bit. One edge later it expects exactly that bit's flag set and every other flag clear. A randomized phase also strikes this overlap repeatedly. There, a behavioural model applies the rule clear-then-merge and is compared against the design on every clock.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int unsigned LINES = 4;
    localparam int unsigned REG_W = 2 * LINES;

    typedef logic [LINES-1:0] line_vec_t;

    // How a change flag reacts to its reported level
    typedef enum logic [1:0] {
        DET_ANY  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2
    } det_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                stage_q[s] <= {W{RST_VAL}};
            end
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
#(
    parameter int unsigned W         = LINES,
    parameter logic [W-1:0] FALL_ONLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic         clr_i,
    output logic [W-1:0] delta_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] delta_q;

    for (genvar i = 0; i < int'(W); i++) begin : g_det
        localparam det_e KIND = FALL_ONLY[i] ? DET_FALL : DET_ANY;
        if (KIND == DET_FALL) begin : g_fall
            assign hit[i] = prev_q[i] & ~lvl_i[i];
        end else if (KIND == DET_RISE) begin : g_rise
            assign hit[i] = ~prev_q[i] & lvl_i[i];
        end else begin : g_any
            assign hit[i] = prev_q[i] ^ lvl_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= lvl_i;
            // clear first, then merge this edge's change so it survives a read
            delta_q <= (clr_i ? '0 : delta_q) | hit;
        end
    end

    assign delta_o = delta_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] modem_n_i,
    input  logic             rd_strobe_i,
    input  logic             loop_en_i,
    input  logic [LINES-1:0] mctl_i,
    input  logic             msi_en_i,
    output logic [REG_W-1:0] status_o,
    output logic             irq_o
);
    // ring line (index 2) flags only its trailing edge
    localparam line_vec_t RING_MASK = line_vec_t'(4'b0100);

    line_vec_t pin_sync;
    line_vec_t lvl;
    line_vec_t delta;

    msr_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (modem_n_i),
        .q_o   (pin_sync)
    );

    always_comb begin
        lvl = loop_en_i ? mctl_i : ~pin_sync;
    end

    msr_delta #(
        .W         (LINES),
        .FALL_ONLY (RING_MASK)
    ) u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl),
        .clr_i   (rd_strobe_i),
        .delta_o (delta)
    );

    assign status_o = {lvl, delta};
    assign irq_o    = msi_en_i & (|delta);
endmodule

// File: rtl/modem_status_reg_chk.sv
module modem_status_reg_chk
    import msr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe_i,
    input logic             loop_en_i,
    input logic [LINES-1:0] mctl_i,
    input logic             msi_en_i,
    input logic [REG_W-1:0] status_o,
    input logic             irq_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_en_i || status_o[3:0] == '0) |-> !irq_o);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en_i && status_o[3:0] != '0) |-> irq_o);

    // R8
    loop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en_i |-> (status_o[7:4] == mctl_i));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rd_strobe_i && loop_en_i && $past(loop_en_i) && mctl_i == $past(mctl_i))
        |=> (status_o[3:0] == '0));

    // R5
    ring_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rd_strobe_i && loop_en_i && $past(loop_en_i)
         && (mctl_i[2] || !$past(mctl_i[2])))
        |=> !status_o[2]);
endmodule

bind modem_status_reg modem_status_reg_chk u_chk (.*);

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] modem_n_i = 4'hF;
    logic       rd_strobe_i = 1'b0;
    logic       loop_en_i = 1'b0;
    logic [3:0] mctl_i = 4'h0;
    logic       msi_en_i = 1'b0;
    logic [7:0] status_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    modem_status_reg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .modem_n_i   (modem_n_i),
        .rd_strobe_i (rd_strobe_i),
        .loop_en_i   (loop_en_i),
        .mctl_i      (mctl_i),
        .msi_en_i    (msi_en_i),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    // behavioural model: pin history queue, previous level, sticky flags
    logic [3:0] pin_hist[$];
    logic [3:0] m_prev  = 4'h0;
    logic [3:0] m_flags = 4'h0;

    function automatic logic [3:0] m_level();
        logic [3:0] seen;
        seen = (pin_hist.size() > 0) ? pin_hist[0] : 4'hF;
        return loop_en_i ? mctl_i : ~seen;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist = {4'hF, 4'hF};
            m_prev   = 4'h0;
            m_flags  = 4'h0;
        end else begin
            logic [3:0] now;
            logic [3:0] chg;
            now = m_level();
            chg = now ^ m_prev;
            chg[2] = m_prev[2] && !now[2];
            m_flags = (rd_strobe_i ? 4'h0 : m_flags) | chg;
            m_prev = now;
            void'(pin_hist.pop_front());
            pin_hist.push_back(modem_n_i);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] el;
            el = m_level();
            check(status_o[7:4] == el, loop_en_i ? "R8 levels" : "R2 levels",
                  status_o[7:4], el);
            check(status_o[3:0] == m_flags, "R3 R4 R5 R6 R10 flags",
                  status_o[3:0], m_flags);
            check(irq_o == (msi_en_i && m_flags != 0), "R7 irq",
                  irq_o, msi_en_i && m_flags != 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic host_read();
        rd_strobe_i = 1'b1;
        step(1);
        rd_strobe_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        check(status_o == 8'h00, "R1 reset status", status_o, 8'h00);
        check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);

        msi_en_i = 1'b1;
        modem_n_i[0] = 1'b0;          // clear-to-send asserted
        step(2);
        check(status_o[4] == 1'b1, "R2 cts level after two edges", status_o[4], 1);
        step(1);
        check(status_o[0] == 1'b1, "R3 cts flag", status_o[0], 1);
        check(irq_o == 1'b1, "R7 irq raised", irq_o, 1);
        step(6);
        check(status_o[3:0] == 4'b0001, "R10 flag held", status_o[3:0], 1);
        host_read();
        check(status_o[3:0] == 4'h0, "R6 read clears", status_o[3:0], 0);
        check(irq_o == 1'b0, "R7 irq dropped", irq_o, 0);

        modem_n_i[2] = 1'b0;          // ring pin high->low: no flag
        step(3);
        check(status_o[6] == 1'b1, "R2 ring level", status_o[6], 1);
        check(status_o[2] == 1'b0, "R5 leading ring edge ignored", status_o[2], 0);
        modem_n_i[2] = 1'b1;          // ring pin low->high: flag
        step(3);
        check(status_o[2] == 1'b1, "R5 trailing ring edge", status_o[2], 1);

        modem_n_i[3] = 1'b0;
        modem_n_i[1] = 1'b0;
        step(3);
        check(status_o[3] == 1'b1, "R4 carrier flag", status_o[3], 1);
        check(status_o[1] == 1'b1, "R3 dsr flag", status_o[1], 1);
        host_read();
        modem_n_i[1] = 1'b1;          // dsr release also flags
        step(3);
        check(status_o[1] == 1'b1, "R3 dsr release flag", status_o[1], 1);

        mctl_i = 4'b0101;
        loop_en_i = 1'b1;
        step(1);
        check(status_o[7:4] == 4'b0101, "R8 loop levels", status_o[7:4], 4'b0101);
        host_read();
        step(1);
        modem_n_i = 4'h0;             // pins ignored in loopback
        step(3);
        check(status_o == 8'h50, "R8 pins ignored", status_o, 8'h50);
        mctl_i[1] = 1'b1;
        step(1);
        check(status_o[1] == 1'b1, "R9 loop dtr toggle", status_o[1], 1);
        host_read();
        rd_strobe_i = 1'b1;           // read and change share an edge
        mctl_i[0] = 1'b0;
        step(1);
        rd_strobe_i = 1'b0;
        check(status_o[3:0] == 4'b0001, "R6 same-edge change kept", status_o[3:0], 1);
        mctl_i[2] = 1'b0;
        step(1);
        check(status_o[2] == 1'b1, "R9 loop aux1 fall", status_o[2], 1);
        msi_en_i = 1'b0;
        #1;
        check(irq_o == 1'b0, "R7 irq masked", irq_o, 0);

        for (int k = 0; k < 400; k++) begin
            modem_n_i   = ($urandom_range(0, 3) == 0) ? 4'($urandom) : modem_n_i;
            mctl_i      = ($urandom_range(0, 2) == 0) ? 4'($urandom) : mctl_i;
            rd_strobe_i = ($urandom_range(0, 3) == 0);
            msi_en_i    = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 15) == 0) loop_en_i = ~loop_en_i;
            step(1);
        end
        rd_strobe_i = 1'b0;
        step(2);
        finish_run();
    end
endmodule